// File: doc/BRIEF.md
# Odd Residue Multiplier in the Index Domain

This block multiplies two odd N-bit words modulo 2^N and uses no multiplier array to do it. The odd residues modulo 2^N form a group in which every element can be written in exactly one way as (2^N − 1)^s · 3^k mod 2^N. Here s is a single sign bit and k runs from 0 to 2^(N−2) − 1. Each operand is first converted into its pair (s, k). The two sign bits are then combined with an exclusive-or, and the two exponents are added in an (N−2)-bit adder that wraps naturally. A decoder turns the resulting pair back into an odd residue.

The encoder and the decoder are comparator and multiplexer structures over a table of the powers of 3. That table is computed while the design elaborates. As N grows, the path between the operands and the product register gains only one table lookup level on each side of the small adders. The operands arrive with a valid strobe, and the product leaves a register one cycle later together with its own valid flag. Even operands break the contract. When one arrives, an error flag is raised and the product is forced to 1.

Top module: `odd_index_mul`

## Requirements
- R1: While reset is active, and in the first cycle after it, `outValid` and `errFlag` are 0 and `product` equals 1.
- R2: When `inValid` is 1 and both operands are odd, `product` equals (opA × opB) mod 2^N on the clock edge that follows.
- R3: `outValid` equals the value `inValid` had one clock earlier.
- R4: When `inValid` is 1 and bit 0 of `opA` or of `opB` is 0, then after the next edge `errFlag` is 1 and `product` equals 1.
- R5: A cycle with `inValid` at 0 leaves `product` unchanged and drives `errFlag` to 0, whatever the operands are.
- R6: Whenever `outValid` is 1, bit 0 of `product` is 1 or `errFlag` is 1.
- R7: Value 1 is the identity: 1 × b gives b for every odd b.
- R8: The all-ones operand (2^N − 1) negates: (2^N − 1) × b gives 2^N − b for every odd b.
- R9: For N = 4, 9 × 11 gives 3 and 13 × 13 gives 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands are present this cycle |
| opA | input | N | First odd operand |
| opB | input | N | Second odd operand |
| outValid | output | 1 | Product register holds a fresh result |
| errFlag | output | 1 | The last accepted operand pair held an even value |
| product | output | N | Registered product modulo 2^N |

## Verification
The internal assertions assume that the operands are stable and free of unknown bits whenever `inValid` is high. They also assume that the encoder finds an index pair for every odd word, which holds only because −1 is not a power of 3. The stimulus follows these assumptions: it changes inputs only on the falling edge and always drives defined values. Every even-operand case is deliberate, so the error path is exercised without disturbing the product check for odd pairs. Four widths (3 to 6 bits) share a single operand bus, so each sweep over the 6-bit odd pairs also covers every odd pair of the narrower instances.

// File: rtl/odd_index_pkg.sv
package odd_index_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a result this cycle
    logic bad;    // capture the error value 1 instead
  } mulStrobe_t;

  // 3^k mod 2^n, evaluated at elaboration time
  function automatic logic [9:0] pow3At(input int n, input int k);
    int p;
    p = 1;
    for (int j = 0; j < k; j++) p = (p * 3) % (1 << n);
    return p[9:0];
  endfunction

endpackage

// File: rtl/odd_index_encoder.sv
module odd_index_encoder #(
  parameter int N = 8,
  localparam int M = N - 2,
  localparam int Q = 1 << M
) (
  input  logic [N-1:0] value,
  output logic         signBit,
  output logic [M-1:0] powIdx,
  output logic         found
);
  import odd_index_pkg::*;

  logic [Q-1:0] hitPos;
  logic [Q-1:0] hitNeg;

  for (genvar i = 0; i < Q; i++) begin : g_cmp
    localparam logic [N-1:0] P = N'(pow3At(N, i));
    localparam logic [N-1:0] NP = N'(~P + N'(1));
    assign hitPos[i] = (value == P);
    assign hitNeg[i] = (value == NP);
  end

  always_comb begin
    powIdx = '0;
    for (int i = 0; i < Q; i++) begin
      if (hitPos[i] || hitNeg[i]) powIdx = powIdx | M'(i);
    end
  end

  assign signBit = |hitNeg;
  assign found   = |(hitPos | hitNeg);

endmodule

// File: rtl/odd_index_decoder.sv
module odd_index_decoder #(
  parameter int N = 8,
  localparam int M = N - 2,
  localparam int Q = 1 << M
) (
  input  logic         signBit,
  input  logic [M-1:0] powIdx,
  output logic [N-1:0] value
);
  import odd_index_pkg::*;

  logic [N-1:0] powTab [Q];
  logic [N-1:0] base;

  for (genvar i = 0; i < Q; i++) begin : g_tab
    assign powTab[i] = N'(pow3At(N, i));
  end

  always_comb begin
    base = powTab[0];
    for (int i = 0; i < Q; i++) begin
      if (powIdx == M'(i)) base = powTab[i];
    end
  end

  assign value = signBit ? (~base + N'(1)) : base;

endmodule

// File: rtl/odd_mul_datapath.sv
module odd_mul_datapath
  import odd_index_pkg::*;
#(
  parameter int N = 8,
  localparam int M = N - 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  mulStrobe_t   strobe,
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  output logic [N-1:0] product
);

  logic         signA, signB, foundA, foundB, signSum;
  logic [M-1:0] idxA, idxB, idxSum;
  logic [N-1:0] decoded;

  odd_index_encoder #(.N(N)) i_encA (
    .value(opA), .signBit(signA), .powIdx(idxA), .found(foundA));
  odd_index_encoder #(.N(N)) i_encB (
    .value(opB), .signBit(signB), .powIdx(idxB), .found(foundB));

  // adder pair: modulo 2 and modulo 2^(N-2), in parallel
  assign signSum = signA ^ signB;
  assign idxSum  = idxA + idxB;

  odd_index_decoder #(.N(N)) i_dec (
    .signBit(signSum), .powIdx(idxSum), .value(decoded));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               product <= N'(1);
    else if (strobe.load)    product <= strobe.bad ? N'(1) : decoded;
  end

  // R2
  encode_found_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.bad) |-> (foundA && foundB));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(product));

endmodule

// File: rtl/odd_mul_ctrl.sv
module odd_mul_ctrl
  import odd_index_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       lsbA,
  input  logic       lsbB,
  output mulStrobe_t strobe,
  output logic       outValid,
  output logic       errFlag
);

  assign strobe.load = inValid;
  assign strobe.bad  = inValid && !(lsbA && lsbB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      outValid <= inValid;
      errFlag  <= strobe.bad;
    end
  end

  // R4
  even_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (!lsbA || !lsbB)) |=> (errFlag && outValid));

  // R5
  idle_noerr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !errFlag);

endmodule

// File: rtl/odd_index_mul.sv
module odd_index_mul
  import odd_index_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  output logic         outValid,
  output logic         errFlag,
  output logic [N-1:0] product
);

  mulStrobe_t strobe;

  odd_mul_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .lsbA(opA[0]), .lsbB(opB[0]),
    .strobe(strobe), .outValid(outValid), .errFlag(errFlag));

  odd_mul_datapath #(.N(N)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opA(opA), .opB(opB), .product(product));

  // R6
  odd_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (product[0] || errFlag));

  // R4
  err_product_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (product == N'(1)));

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

endmodule

// File: tb/test_odd_index_mul.sv
module test_odd_index_mul;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [5:0] a = '0;
  logic [5:0] b = '0;

  logic       ov6, ov5, ov4, ov3, er6, er5, er4, er3;
  logic [5:0] p6;
  logic [4:0] p5;
  logic [3:0] p4;
  logic [2:0] p3;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  odd_index_mul #(.N(6)) i_odd_index_mul (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(a), .opB(b),
    .outValid(ov6), .errFlag(er6), .product(p6));
  odd_index_mul #(.N(5)) i_odd_index_mul_n5 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(a[4:0]), .opB(b[4:0]),
    .outValid(ov5), .errFlag(er5), .product(p5));
  odd_index_mul #(.N(4)) i_odd_index_mul_n4 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(a[3:0]), .opB(b[3:0]),
    .outValid(ov4), .errFlag(er4), .product(p4));
  odd_index_mul #(.N(3)) i_odd_index_mul_n3 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(a[2:0]), .opB(b[2:0]),
    .outValid(ov3), .errFlag(er3), .product(p3));

  // N=4 vectors: {a, b, expected}
  localparam int NV = 10;
  localparam logic [3:0] VEC [NV][3] = '{
    '{4'd9, 4'd11, 4'd3},  '{4'd13, 4'd13, 4'd9}, '{4'd1, 4'd1, 4'd1},
    '{4'd15, 4'd15, 4'd1}, '{4'd7, 4'd5, 4'd3},   '{4'd3, 4'd3, 4'd9},
    '{4'd5, 4'd7, 4'd3},   '{4'd15, 4'd3, 4'd13}, '{4'd11, 4'd11, 4'd9},
    '{4'd13, 4'd15, 4'd3}};

  task automatic checkVal(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int modMul(input int x, input int y, input int n);
    int mk;
    mk = (1 << n) - 1;
    return ((x & mk) * (y & mk)) & mk;
  endfunction

  // drive at falling edge, result is read at the next falling edge
  task automatic apply(input int x, input int y, input logic v);
    inValid = v;
    a = 6'(x);
    b = 6'(y);
    @(negedge clk);
  endtask

  task automatic checkAll(input string req, input int x, input int y);
    checkVal({req, " n6"}, int'(p6), modMul(x, y, 6));
    checkVal({req, " n5"}, int'(p5), modMul(x, y, 5));
    checkVal({req, " n4"}, int'(p4), modMul(x, y, 4));
    checkVal({req, " n3"}, int'(p3), modMul(x, y, 3));
    checkVal({req, " odd R6"}, int'(p6[0] & p5[0] & p4[0] & p3[0]), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [5:0] held;
    // R1 during and after reset
    repeat (3) @(negedge clk);
    checkVal("R1 product in reset", int'(p6), 1);
    checkVal("R1 flags in reset", int'({ov6, er6, ov3, er3}), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 product after reset", int'(p6) + int'(p3), 2);
    checkVal("R1 flags after reset", int'({ov6, er6, ov4, er4}), 0);

    // R9 vector table, N=4
    for (int i = 0; i < NV; i++) begin
      apply(int'(VEC[i][0]), int'(VEC[i][1]), 1'b1);
      checkVal("R9 table", int'(p4), int'(VEC[i][2]));
      checkVal("R3 outValid", int'(ov4), 1);
    end

    // R2 exhaustive odd pairs, all widths at once
    for (int x = 1; x < 64; x += 2) begin
      for (int y = 1; y < 64; y += 2) begin
        apply(x, y, 1'b1);
        checkAll("R2 sweep", x, y);
        checkVal("R3 valid", int'({ov6, ov5, ov4, ov3}), 15);
        checkVal("R4 no error on odd", int'({er6, er5, er4, er3}), 0);
      end
    end

    // R7 identity and R8 negation
    for (int y = 1; y < 64; y += 2) begin
      apply(1, y, 1'b1);
      checkVal("R7 identity", int'(p6), y);
      apply(63, y, 1'b1);
      checkVal("R8 negate", int'(p6), (64 - y) & 63);
    end

    // R4 even operands
    apply(9, 11, 1'b1);
    apply(8, 11, 1'b1);
    checkVal("R4 err A even", int'({er6, er5, er4, er3}), 15);
    checkVal("R4 product one", int'(p6) + int'(p5) + int'(p4) + int'(p3), 4);
    apply(7, 2, 1'b1);
    checkVal("R4 err B even", int'(er6), 1);
    checkVal("R4 product one B", int'(p6), 1);
    apply(0, 0, 1'b1);
    checkVal("R4 both even", int'({er6, p6}), {1'b1, 6'd1});

    // R5 idle cycles hold the product and clear the flag
    apply(13, 7, 1'b1);
    held = p6;
    checkVal("R5 setup", int'(held), modMul(13, 7, 6));
    apply(5, 5, 1'b0);
    checkVal("R5 hold", int'(p6), int'(held));
    checkVal("R3 valid low", int'(ov6), 0);
    apply(4, 6, 1'b0);
    checkVal("R5 even ignored when idle", int'({er6, er3}), 0);
    checkVal("R5 hold again", int'(p6), int'(held));
    apply(8, 1, 1'b1);
    apply(3, 3, 1'b0);
    checkVal("R5 error cleared", int'(er6), 0);
    checkVal("R5 error product held", int'(p6), 1);

    // R1 reset again mid-run
    apply(3, 5, 1'b1);
    rstN = 1'b0;
    @(negedge clk);
    checkVal("R1 re-reset", int'({ov6, er6, p6}), 1);
    rstN = 1'b1;
    inValid = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule